// File: doc/BRIEF.md
# Double-Rate Synchronous Serial Link

This block moves parallel words across a single serial data line that shares one clock with the far end. Both halves of every clock period carry a bit. The line takes a new value after each rising edge and again after each falling edge, so a 16-bit word crosses in eight clock periods rather than sixteen. The block has a transmit half and a receive half. The transmit half captures a parallel word while its load input is high, then serializes it most significant bit first once load drops. A frame output marks the periods in which the line carries data. The receive half samples the line on the edge opposite to the one that launched each bit, reassembles the word, and presents it with a one-period valid pulse.

The two halves coordinate through a small handshake. The receive half drives a ready output when it can take a word. It drives a one-period acknowledge along with the valid pulse. The transmit half reports busy from the moment it captures a word until its last bit is on the line. It then refuses new loads until an acknowledge arrives.

In normal use the serial data and frame outputs of one instance feed the serial inputs of another, and its ready and acknowledge outputs return to the transmitter's handshake inputs. Either half may also be used alone.

Top module: `ddrSerialLink`

## Requirements
- R1: On a rising clock edge where the transmitter is idle, `txRdy` is high and `load` is high, the transmitter captures `txWord`. While `load` stays high on later rising edges it captures again. The word present on the last rising edge with `load` high is the word that is sent.
- R2: The first rising edge at which `load` is seen low after a capture launches bit 15 on `txData`. Number that edge k=0. After rising edge k (k = 0..7), the line holds bit 15-2k of the word. After the falling edge that follows, it holds bit 14-2k. All 16 bits go out in 8 clock periods.
- R3: `txFrame` is high after each of the rising edges k = 0..7 and low after rising edge k = 8. It stays low while the transmitter is idle, loaded or waiting.
- R4: `busy` goes high after the rising edge that first captures a word. It stays high through the whole shift, including both halves of period 7, and is low after rising edge k = 8.
- R5: A high `load` has no effect on the transmitter in three cases: while it is shifting, while it is waiting for acknowledge, and while it is idle with `txRdy` low. `busy` stays as it was and the serial stream and the received word are unchanged.
- R6: After the last bit, the transmitter accepts no load until it has seen `txAck` high on a rising edge. From the next rising edge onward, a load is accepted again.
- R7: The receiver samples `rxData` on the falling edge for bits launched on a rising edge, and on the rising edge for bits launched on a falling edge. This happens only while `rxFrame` is high. After edge k = 8, `rxWord` equals the sent word, and `rxValid` and `rxAck` are high for exactly one clock period.
- R8: `rxRdy` is high whenever no frame is seen. It is low from the first rising edge that sees `rxFrame` high until `rxValid` clears, and it returns high in the same period that `rxValid` drops.
- R9: While `rstN` is low, the block holds these values: `busy`, `txFrame`, `txData`, `rxValid` and `rxAck` low; `rxRdy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used on the data line |
| rstN | input | 1 | Asynchronous reset, active low |
| load | input | 1 | High captures the parallel word; low lets the shift start |
| txWord | input | 16 | Parallel word to send |
| txRdy | input | 1 | Receiver ready, returned from the far end |
| txAck | input | 1 | Receiver acknowledge, returned from the far end |
| txData | output | 1 | Serial data, new bit after every clock edge |
| txFrame | output | 1 | High while the line carries word bits |
| busy | output | 1 | Transmitter holds a word not yet fully sent |
| rxData | input | 1 | Serial data from the far end |
| rxFrame | input | 1 | Frame marker from the far end |
| rxWord | output | 16 | Reassembled word |
| rxValid | output | 1 | One-period pulse when `rxWord` is new |
| rxAck | output | 1 | Acknowledge to the far end |
| rxRdy | output | 1 | Ready to accept a word |

## Verification
The link is tried with all-zero, all-one and both alternating words. The alternating words, 0xAAAA and 0x5555, put every one-bit on only rising-launched or only falling-launched slots, so they expose any swap between the two edge paths. A walking one across all sixteen positions separates each bit's slot and the order of the pairs. Random words, sent back to back, check the handshake turnaround at full rate. Other runs hold load for several cycles with a changing word, poke load during a shift, hold ready low, and delay acknowledge; these show which word is captured and that loads arriving at the wrong time are refused.

// File: rtl/ddrLinkPkg.sv
package ddrLinkPkg;

  // strobes from transmit control to transmit datapath
  typedef struct packed {
    logic capture;  // take the parallel word
    logic launch;   // put the next bit pair on the line
  } txStrobe_t;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_LOADED,
    TX_SHIFT,
    TX_WAITACK
  } txState_t;

endpackage

// File: rtl/ddrTxCtrl.sv
module ddrTxCtrl
  import ddrLinkPkg::*;
#(
  parameter int PAIRS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      load,
  input  logic      rdyIn,
  input  logic      ackIn,
  output txStrobe_t stb,
  output logic      busy,
  output logic      frame
);

  localparam int CNT_W = $clog2(PAIRS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PAIRS);

  txState_t state;
  logic [CNT_W-1:0] pairCnt;

  always_comb begin
    stb.capture = load && (((state == TX_IDLE) && rdyIn) || (state == TX_LOADED));
    stb.launch  = ((state == TX_LOADED) && !load) ||
                  ((state == TX_SHIFT) && (pairCnt != LAST_CNT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= TX_IDLE;
      pairCnt <= '0;
      frame   <= 1'b0;
    end else begin
      frame <= stb.launch;
      unique case (state)
        TX_IDLE:    if (stb.capture) state <= TX_LOADED;
        TX_LOADED:  if (!load) begin
                      state   <= TX_SHIFT;
                      pairCnt <= CNT_W'(1);
                    end
        TX_SHIFT:   if (pairCnt == LAST_CNT) begin
                      state   <= TX_WAITACK;
                      pairCnt <= '0;
                    end else begin
                      pairCnt <= pairCnt + 1'b1;
                    end
        TX_WAITACK: if (ackIn) state <= TX_IDLE;
        default:    state <= TX_IDLE;
      endcase
    end
  end

  assign busy = (state == TX_LOADED) || (state == TX_SHIFT);

  // R4
  busy_needs_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(load));

  // R3
  frame_within_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    frame |-> busy);

  // R5
  no_capture_unready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !rdyIn) |=> !busy);

  // R6
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == TX_WAITACK) && !ackIn) |=> !busy);

endmodule

// File: rtl/ddrTxPath.sv
module ddrTxPath
  import ddrLinkPkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  logic [WORD_W-1:0] word,
  output logic              sOut
);

  logic [WORD_W-1:0] shiftReg;
  logic riseQ;      // rising-edge half of the dual-edge output register
  logic fallQ;      // falling-edge half
  logic pendLo;     // second bit of the current pair, waits for the falling edge
  logic pendValid;  // a pair was launched on the last rising edge

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      riseQ     <= 1'b0;
      pendLo    <= 1'b0;
      pendValid <= 1'b0;
    end else begin
      pendValid <= stb.launch;
      if (stb.capture) begin
        shiftReg <= word;
      end else if (stb.launch) begin
        shiftReg <= {shiftReg[WORD_W-3:0], 2'b00};
        riseQ    <= shiftReg[WORD_W-1] ^ fallQ;
        pendLo   <= shiftReg[WORD_W-2];
      end
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      fallQ <= 1'b0;
    end else if (pendValid) begin
      fallQ <= pendLo ^ riseQ;
    end
  end

  // line value is the XOR of both halves, so each edge sets it without a clock mux
  assign sOut = riseQ ^ fallQ;

endmodule

// File: rtl/ddrRx.sv
module ddrRx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sIn,
  input  logic              frameIn,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic              ack,
  output logic              rdy
);

  localparam int PAIRS = WORD_W / 2;
  localparam int CNT_W = $clog2(PAIRS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAIRS - 1);

  logic [PAIRS-1:0] negShift;  // bits launched on rising edges
  logic [PAIRS-1:0] posShift;  // bits launched on falling edges
  logic [PAIRS-1:0] posNext;
  logic [WORD_W-1:0] assembled;
  logic [CNT_W-1:0] pairCnt;
  logic lastPair;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) negShift <= '0;
    else if (frameIn) negShift <= {negShift[PAIRS-2:0], sIn};
  end

  assign posNext  = {posShift[PAIRS-2:0], sIn};
  assign lastPair = frameIn && (pairCnt == LAST_IDX);

  for (genvar i = 0; i < PAIRS; i++) begin : gInterleave
    assign assembled[2*i+1] = negShift[i];
    assign assembled[2*i]   = posNext[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posShift <= '0;
      pairCnt  <= '0;
      rxWord   <= '0;
      rxValid  <= 1'b0;
      ack      <= 1'b0;
      rdy      <= 1'b1;
    end else begin
      rxValid <= lastPair;
      ack     <= lastPair;
      rdy     <= !frameIn;
      if (frameIn) begin
        posShift <= posNext;
        pairCnt  <= lastPair ? '0 : pairCnt + 1'b1;
      end
      if (lastPair) rxWord <= assembled;
    end
  end

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R7
  ack_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ack);

  // R8
  ready_after_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> rdy);

  // R8
  not_ready_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !rdy);

endmodule

// File: rtl/ddrSerialLink.sv
module ddrSerialLink #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txRdy,
  input  logic              txAck,
  output logic              txData,
  output logic              txFrame,
  output logic              busy,
  input  logic              rxData,
  input  logic              rxFrame,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic              rxAck,
  output logic              rxRdy
);

  localparam int PAIRS = WORD_W / 2;

  ddrLinkPkg::txStrobe_t txStb;

  ddrTxCtrl #(.PAIRS(PAIRS)) uTxCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .load  (load),
    .rdyIn (txRdy),
    .ackIn (txAck),
    .stb   (txStb),
    .busy  (busy),
    .frame (txFrame)
  );

  ddrTxPath #(.WORD_W(WORD_W)) uTxPath (
    .clk  (clk),
    .rstN (rstN),
    .stb  (txStb),
    .word (txWord),
    .sOut (txData)
  );

  ddrRx #(.WORD_W(WORD_W)) uRx (
    .clk     (clk),
    .rstN    (rstN),
    .sIn     (rxData),
    .frameIn (rxFrame),
    .rxWord  (rxWord),
    .rxValid (rxValid),
    .ack     (rxAck),
    .rdy     (rxRdy)
  );

endmodule

// File: tb/ddrSerialLink_test.sv
module ddrSerialLink_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic        load;
  logic [15:0] txWord;
  logic        rdyBlock, ackOverride, ackManual;
  logic        txData, txFrame, busy, rxValid, rxAck, rxRdy;
  logic [15:0] rxWord;
  logic        txRdyIn, txAckIn;

  assign txRdyIn = rxRdy & ~rdyBlock;
  assign txAckIn = ackOverride ? ackManual : rxAck;

  ddrSerialLink uut (
    .clk(clk), .rstN(rstN), .load(load), .txWord(txWord),
    .txRdy(txRdyIn), .txAck(txAckIn),
    .txData(txData), .txFrame(txFrame), .busy(busy),
    .rxData(txData), .rxFrame(txFrame),
    .rxWord(rxWord), .rxValid(rxValid), .rxAck(rxAck), .rxRdy(rxRdy)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one word through the loop; hold = load cycles, poke = stray load mid-shift
  task automatic sendWord(input logic [15:0] w, input int hold, input bit poke);
    @(negedge clk);
    load   = 1'b1;
    txWord = (hold > 1) ? ~w : w;
    for (int i = 1; i < hold; i++) begin
      @(negedge clk);
      if (i == hold - 1) txWord = w;  // R1 last cycle's word counts
    end
    @(negedge clk);
    load   = 1'b0;
    txWord = 16'h0;
    #2;
    check("R4 busy after capture", busy, 1'b1);
    check("R3 frame low while loaded", txFrame, 1'b0);
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #2;
      check("R2 rising-edge bit", txData, w[15-2*k]);
      check("R3 frame during shift", txFrame, 1'b1);
      @(negedge clk);
      if (poke && k == 3) begin load = 1'b1; txWord = ~w; end
      if (poke && k == 4) begin load = 1'b0; txWord = 16'h0; end
      #2;
      check("R2 falling-edge bit", txData, w[14-2*k]);
      check("R4 busy during shift", busy, 1'b1);
    end
    @(posedge clk); #2;
    check("R4 busy low after last bit", busy, 1'b0);
    check("R3 frame low after shift", txFrame, 1'b0);
    check("R7 rxValid pulse", rxValid, 1'b1);
    check("R7 rxWord", rxWord, w);
    check("R7 rxAck pulse", rxAck, 1'b1);
    check("R8 rdy low with valid", rxRdy, 1'b0);
    @(posedge clk); #2;
    check("R7 rxValid one period", rxValid, 1'b0);
    check("R8 rdy back", rxRdy, 1'b1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rstN = 1'b0; load = 1'b0; txWord = 16'h0;
    rdyBlock = 1'b0; ackOverride = 1'b0; ackManual = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    // R9 reset values
    check("R9 busy", busy, 1'b0);
    check("R9 frame", txFrame, 1'b0);
    check("R9 data", txData, 1'b0);
    check("R9 valid", rxValid, 1'b0);
    check("R9 ack", rxAck, 1'b0);
    check("R9 rdy", rxRdy, 1'b1);
    @(negedge clk);
    rstN = 1'b1;

    sendWord(16'h0000, 1, 1'b0);
    sendWord(16'hFFFF, 1, 1'b0);
    sendWord(16'hAAAA, 1, 1'b0);
    sendWord(16'h5555, 1, 1'b0);
    for (int b = 0; b < 16; b++) sendWord(16'h1 << b, 1, 1'b0);

    // R1 long load, R5 stray load during shift
    sendWord(16'h1234, 3, 1'b0);
    sendWord(16'hC3A5, 1, 1'b1);
    sendWord(16'h0F0F, 4, 1'b1);

    // R5 ready held low: load refused
    rdyBlock = 1'b1;
    @(negedge clk); load = 1'b1; txWord = 16'hDEAD;
    @(negedge clk); load = 1'b0; #2;
    check("R5 load ignored when not ready", busy, 1'b0);
    @(negedge clk); #2;
    check("R5 no frame when not ready", txFrame, 1'b0);
    rdyBlock = 1'b0;
    sendWord(16'h8001, 1, 1'b0);

    // R6 acknowledge withheld: next load refused until it arrives
    ackOverride = 1'b1;
    sendWord(16'h7E81, 1, 1'b0);
    @(negedge clk); load = 1'b1; txWord = 16'hBEEF;
    @(negedge clk); load = 1'b0; #2;
    check("R6 load refused before ack", busy, 1'b0);
    @(negedge clk); #2;
    check("R6 no frame before ack", txFrame, 1'b0);
    ackManual = 1'b1;
    @(negedge clk); ackManual = 1'b0; ackOverride = 1'b0;
    sendWord(16'h2468, 1, 1'b0);

    // back-to-back random words
    for (int n = 0; n < 24; n++) sendWord(16'($urandom), 1, 1'b0);

    summary();
  end

endmodule